// File: doc/BRIEF.md
# Per-Processor Device Interrupt Router

This block collects up to 64 device interrupt lines into one shared pending-request vector and fans it out to up to four processors. Each processor has its own enable vector. The block keeps a per-processor active vector equal to that enable vector ANDed with the shared pending vector. A registered interrupt output per processor is high whenever any bit of its active vector is set.

Devices raise and drop requests with single-cycle set and clear strobes, each of which carries an interrupt number. Software reaches the enable, active and pending vectors through a 64-bit register port. Each request on that port gets a registered response, with an error flag for anything the block does not accept. A clear aimed at a request that is not pending is reported on a one-cycle spurious strobe.

Top module: `irq_router`

## Requirements
- R1: After reset every enable, active and pending vector reads zero, every `irq_o` bit is low and `spurious_o` is low.
- R2: A set strobe with number n sets bit n of the pending vector. The new value is readable through the register port from the cycle after the strobe.
- R3: The active vector of processor c always equals enable vector c AND the pending vector. It is updated in the cycle after either of them changes.
- R4: `irq_o[c]` is high exactly when the active vector of processor c is nonzero, and it changes in the same cycle as that vector.
- R5: A clear strobe with number n clears pending bit n. When a set and a clear name the same number in the same cycle, the set wins and the bit ends up set.
- R6: A clear strobe whose target pending bit was already zero leaves the pending vector unchanged and drives `spurious_o` high for one cycle, in the cycle after the strobe. A clear of a set bit leaves `spurious_o` low.
- R7: Writing an enable vector that drops an active bit withdraws that request from the processor. Writing one that adds a bit whose request is pending raises it.
- R8: The register index is the byte address shifted right by 6, and the low 6 address bits are ignored. Index c (0 to 3) is enable vector c, index 4+c is active vector c, and index 8 is the pending vector.
- R9: Only size code 3 (8 bytes) is accepted. Codes 0, 1 and 2 (1, 2 and 4 bytes) give an error response and change no state.
- R10: Writes to the active or pending vectors, and any access to an index above 8, give an error response with read data zero and change no state.
- R11: Every request on the register port gets exactly one response, one cycle later. A read without error returns the addressed vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_set_valid | input | 1 | Device request set strobe |
| dev_set_num | input | 6 | Interrupt number to set |
| dev_clr_valid | input | 1 | Device request clear strobe |
| dev_clr_num | input | 6 | Interrupt number to clear |
| csr_req | input | 1 | Register port request |
| csr_we | input | 1 | 1 = write, 0 = read |
| csr_addr | input | 12 | Byte address |
| csr_size | input | 2 | Access size code (3 = 8 bytes) |
| csr_wdata | input | 64 | Write data |
| csr_resp | output | 1 | Response valid, one cycle after request |
| csr_err | output | 1 | Error response |
| csr_rdata | output | 64 | Read data |
| irq_o | output | 4 | Per-processor interrupt |
| spurious_o | output | 1 | Clear of a non-pending request |

## Verification
The hardest situations to reach are a set and a clear that collide on one number in the same cycle, and an enable write that lands while requests are pending. In both, the result depends on the order of updates inside a single clock. The bench first fills the pending vector one interrupt number at a time, using four enable vectors with different bit patterns, and checks every processor output after each step. It then drives colliding strobes and rewrites the enables over a known pending state. Clears of bits that are already zero are issued right after the drain sweep, so the spurious strobe is seen against a known-empty vector.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } csr_size_e;

  localparam int unsigned IDX_SHIFT = 6;
endpackage

// File: rtl/irq_raw_reg.sv
module irq_raw_reg #(
  parameter int NUM_SRC = 64,
  parameter int SRC_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               set_v,
  input  logic [SRC_W-1:0]   set_n,
  input  logic               clr_v,
  input  logic [SRC_W-1:0]   clr_n,
  output logic [NUM_SRC-1:0] raw_q,
  output logic [NUM_SRC-1:0] raw_nxt,
  output logic               spurious_q
);
  // clear first, then set: a same-number collision leaves the bit set
  always_comb begin
    raw_nxt = raw_q;
    if (clr_v) raw_nxt[clr_n] = 1'b0;
    if (set_v) raw_nxt[set_n] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q      <= '0;
      spurious_q <= 1'b0;
    end else begin
      raw_q      <= raw_nxt;
      spurious_q <= clr_v && !raw_q[clr_n];
    end
  end
endmodule

// File: rtl/irq_cpu_slice.sv
module irq_cpu_slice #(
  parameter int NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mask_we,
  input  logic [NUM_SRC-1:0] wdata,
  input  logic [NUM_SRC-1:0] raw_nxt,
  output logic [NUM_SRC-1:0] mask_q,
  output logic [NUM_SRC-1:0] act_q,
  output logic               irq_q
);
  logic [NUM_SRC-1:0] mask_nxt;
  logic [NUM_SRC-1:0] act_nxt;

  always_comb begin
    mask_nxt = mask_we ? wdata : mask_q;
    act_nxt  = mask_nxt & raw_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      act_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      mask_q <= mask_nxt;
      act_q  <= act_nxt;
      irq_q  <= |act_nxt;
    end
  end
endmodule

// File: rtl/irq_csr_decode.sv
module irq_csr_decode
  import irq_router_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int NUM_SRC = 64,
  parameter int ADDR_W  = 12
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            req,
  input  logic                            we,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [1:0]                      size,
  input  logic [NUM_CPU-1:0][NUM_SRC-1:0] mask_q,
  input  logic [NUM_CPU-1:0][NUM_SRC-1:0] act_q,
  input  logic [NUM_SRC-1:0]              raw_q,
  output logic [NUM_CPU-1:0]              mask_we,
  output logic                            resp_q,
  output logic                            err_q,
  output logic [NUM_SRC-1:0]              rdata_q
);
  localparam int IDX_W   = ADDR_W - IDX_SHIFT;
  localparam int IDX_RAW = 2 * NUM_CPU;

  logic [IDX_W-1:0]   idx;
  logic               hit_mask, hit_act, hit_raw, size_ok, bad;
  logic [NUM_SRC-1:0] rd_val;

  assign idx = addr[ADDR_W-1:IDX_SHIFT];

  always_comb begin
    hit_mask = 1'b0;
    hit_act  = 1'b0;
    hit_raw  = (idx == IDX_W'(IDX_RAW));
    rd_val   = hit_raw ? raw_q : '0;
    size_ok  = (size == SZ_DWORD);
    for (int c = 0; c < NUM_CPU; c++) begin
      if (idx == IDX_W'(c)) begin
        hit_mask = 1'b1;
        rd_val   = mask_q[c];
      end
      if (idx == IDX_W'(NUM_CPU + c)) begin
        hit_act = 1'b1;
        rd_val  = act_q[c];
      end
    end
    bad = !size_ok || !(hit_mask || hit_act || hit_raw) || (we && !hit_mask);
    for (int c = 0; c < NUM_CPU; c++)
      mask_we[c] = req && we && size_ok && (idx == IDX_W'(c));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_q  <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      resp_q  <= req;
      err_q   <= req && bad;
      rdata_q <= (req && !we && !bad) ? rd_val : '0;
    end
  end
endmodule

// File: rtl/irq_router.sv
module irq_router #(
  parameter int NUM_CPU = 4,
  parameter int NUM_SRC = 64,
  parameter int ADDR_W  = 12,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               dev_set_valid,
  input  logic [SRC_W-1:0]   dev_set_num,
  input  logic               dev_clr_valid,
  input  logic [SRC_W-1:0]   dev_clr_num,
  input  logic               csr_req,
  input  logic               csr_we,
  input  logic [ADDR_W-1:0]  csr_addr,
  input  logic [1:0]         csr_size,
  input  logic [NUM_SRC-1:0] csr_wdata,
  output logic               csr_resp,
  output logic               csr_err,
  output logic [NUM_SRC-1:0] csr_rdata,
  output logic [NUM_CPU-1:0] irq_o,
  output logic               spurious_o
);
  logic [NUM_SRC-1:0]              raw_q, raw_nxt;
  logic [NUM_CPU-1:0][NUM_SRC-1:0] mask_q, act_q;
  logic [NUM_CPU-1:0]              mask_we;

  irq_raw_reg #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_raw (
    .clk(clk), .rst(rst),
    .set_v(dev_set_valid), .set_n(dev_set_num),
    .clr_v(dev_clr_valid), .clr_n(dev_clr_num),
    .raw_q(raw_q), .raw_nxt(raw_nxt), .spurious_q(spurious_o)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    irq_cpu_slice #(.NUM_SRC(NUM_SRC)) u_slice (
      .clk(clk), .rst(rst),
      .mask_we(mask_we[c]), .wdata(csr_wdata), .raw_nxt(raw_nxt),
      .mask_q(mask_q[c]), .act_q(act_q[c]), .irq_q(irq_o[c])
    );
  end

  irq_csr_decode #(.NUM_CPU(NUM_CPU), .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst(rst),
    .req(csr_req), .we(csr_we), .addr(csr_addr), .size(csr_size),
    .mask_q(mask_q), .act_q(act_q), .raw_q(raw_q),
    .mask_we(mask_we), .resp_q(csr_resp), .err_q(csr_err), .rdata_q(csr_rdata)
  );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NUM_CPU = 4,
  parameter int NUM_SRC = 64,
  parameter int SRC_W   = 6
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            dev_set_valid,
  input logic [SRC_W-1:0]                dev_set_num,
  input logic                            dev_clr_valid,
  input logic                            csr_req,
  input logic [1:0]                      csr_size,
  input logic                            csr_resp,
  input logic                            csr_err,
  input logic                            spurious_o,
  input logic [NUM_CPU-1:0]              irq_o,
  input logic [NUM_SRC-1:0]              raw_q,
  input logic [NUM_CPU-1:0][NUM_SRC-1:0] mask_q,
  input logic [NUM_CPU-1:0][NUM_SRC-1:0] act_q
);
  assert_set_lands_R2: assert property (@(posedge clk) disable iff (rst)
    dev_set_valid |=> raw_q[$past(dev_set_num)]);

  assert_spurious_cause_R6: assert property (@(posedge clk) disable iff (rst)
    spurious_o |-> $past(dev_clr_valid));

  assert_bad_size_err_R9: assert property (@(posedge clk) disable iff (rst)
    (csr_req && csr_size != 2'd3) |=> csr_err);

  assert_resp_follows_req_R11: assert property (@(posedge clk) disable iff (rst)
    csr_req |=> csr_resp);

  assert_resp_has_req_R11: assert property (@(posedge clk) disable iff (rst)
    csr_resp |-> $past(csr_req));

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
    assert_active_and_R3: assert property (@(posedge clk) disable iff (rst)
      act_q[c] == (mask_q[c] & raw_q));
    assert_irq_or_R4: assert property (@(posedge clk) disable iff (rst)
      irq_o[c] == (|act_q[c]));
  end
endmodule

bind irq_router irq_router_chk #(.NUM_CPU(NUM_CPU), .NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_chk (
  .clk(clk), .rst(rst),
  .dev_set_valid(dev_set_valid), .dev_set_num(dev_set_num),
  .dev_clr_valid(dev_clr_valid),
  .csr_req(csr_req), .csr_size(csr_size),
  .csr_resp(csr_resp), .csr_err(csr_err),
  .spurious_o(spurious_o), .irq_o(irq_o),
  .raw_q(raw_q), .mask_q(mask_q), .act_q(act_q)
);

// File: tb/irq_router_bench.sv
module irq_router_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCPU = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dev_set_valid = 1'b0, dev_clr_valid = 1'b0;
  logic [5:0]  dev_set_num = '0, dev_clr_num = '0;
  logic        csr_req = 1'b0, csr_we = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [1:0]  csr_size = 2'd3;
  logic [63:0] csr_wdata = '0;
  logic        csr_resp, csr_err, spurious_o;
  logic [63:0] csr_rdata;
  logic [NCPU-1:0] irq_o;

  int n_chk = 0, n_bad = 0;
  logic [63:0] mask_m [NCPU];
  logic [63:0] raw_m = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_router u_irq_router (
    .clk(clk), .rst(rst),
    .dev_set_valid(dev_set_valid), .dev_set_num(dev_set_num),
    .dev_clr_valid(dev_clr_valid), .dev_clr_num(dev_clr_num),
    .csr_req(csr_req), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_size(csr_size), .csr_wdata(csr_wdata),
    .csr_resp(csr_resp), .csr_err(csr_err), .csr_rdata(csr_rdata),
    .irq_o(irq_o), .spurious_o(spurious_o)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic access(input bit we, input logic [11:0] addr, input logic [1:0] sz,
                        input logic [63:0] wd, output logic [63:0] rd, output logic er);
    csr_req = 1'b1; csr_we = we; csr_addr = addr; csr_size = sz; csr_wdata = wd;
    @(posedge clk); @(negedge clk);
    csr_req = 1'b0; csr_we = 1'b0;
    rd = csr_rdata; er = csr_err;
    chk("R11 response one cycle after request", {63'd0, csr_resp}, 64'd1);
  endtask

  task automatic rd_ok(input int idx, input logic [63:0] exp, input string req);
    logic [63:0] d; logic e;
    access(1'b0, 12'(idx * 64), 2'd3, '0, d, e);
    chk(req, {63'd0, e}, 64'd0);
    chk(req, d, exp);
  endtask

  task automatic wr_mask(input int c, input logic [63:0] v, input logic [5:0] off);
    logic [63:0] d; logic e;
    access(1'b1, 12'(c * 64) | 12'(off), 2'd3, v, d, e);
    chk("R8 enable write accepted", {63'd0, e}, 64'd0);
    mask_m[c] = v;
  endtask

  task automatic dev(input bit s, input int sn, input bit cl, input int cn);
    dev_set_valid = s; dev_set_num = 6'(sn);
    dev_clr_valid = cl; dev_clr_num = 6'(cn);
    @(posedge clk); @(negedge clk);
    dev_set_valid = 1'b0; dev_clr_valid = 1'b0;
  endtask

  task automatic chk_irq(input string req);
    logic [NCPU-1:0] e;
    for (int c = 0; c < NCPU; c++) e[c] = |(mask_m[c] & raw_m);
    chk(req, 64'(irq_o), 64'(e));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] d; logic e;
    for (int c = 0; c < NCPU; c++) mask_m[c] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq after reset", 64'(irq_o), 64'd0);
    chk("R1 spurious after reset", {63'd0, spurious_o}, 64'd0);
    for (int i = 0; i < 9; i++) rd_ok(i, 64'd0, "R1 register zero after reset");

    // enables with distinct patterns; R8 low address bits ignored
    wr_mask(0, 64'h5555_5555_5555_5555, 6'd0);
    wr_mask(1, 64'hAAAA_AAAA_AAAA_AAAA, 6'd8);
    wr_mask(2, 64'h0000_0000_FFFF_FFFF, 6'd33);
    wr_mask(3, 64'hFFFF_FFFF_FFFF_FFFF, 6'd63);
    for (int c = 0; c < NCPU; c++) rd_ok(c, mask_m[c], "R8 enable readback by index");

    // fill sweep: R2 R3 R4
    for (int n = 0; n < 64; n++) begin
      dev(1'b1, n, 1'b0, 0);
      raw_m[n] = 1'b1;
      chk_irq("R4 irq during fill");
      rd_ok(8, raw_m, "R2 pending after set");
      for (int c = 0; c < NCPU; c++) rd_ok(4 + c, mask_m[c] & raw_m, "R3 active during fill");
    end

    // drain sweep: R5, R6 no spurious on real clear
    for (int n = 63; n >= 0; n--) begin
      dev(1'b0, 0, 1'b1, n);
      raw_m[n] = 1'b0;
      chk("R6 no spurious on set bit", {63'd0, spurious_o}, 64'd0);
      chk_irq("R4 irq during drain");
      if (n % 8 == 0) begin
        rd_ok(8, raw_m, "R5 pending after clear");
        for (int c = 0; c < NCPU; c++) rd_ok(4 + c, mask_m[c] & raw_m, "R3 active during drain");
      end
    end

    // R6 spurious clear
    for (int n = 0; n < 64; n += 9) begin
      dev(1'b0, 0, 1'b1, n);
      chk("R6 spurious pulse", {63'd0, spurious_o}, 64'd1);
      @(negedge clk);
      chk("R6 spurious one cycle", {63'd0, spurious_o}, 64'd0);
    end
    rd_ok(8, 64'd0, "R6 pending unchanged by spurious clear");

    // R5 collision: set wins
    dev(1'b1, 20, 1'b1, 20);
    raw_m[20] = 1'b1;
    rd_ok(8, raw_m, "R5 set wins same-number collision");
    dev(1'b1, 3, 1'b1, 20);
    raw_m[3] = 1'b1; raw_m[20] = 1'b0;
    rd_ok(8, raw_m, "R5 set and clear different numbers");
    dev(1'b1, 10, 1'b0, 0);
    raw_m[10] = 1'b1;

    // R7 enable rewrites over pending {3,10}
    wr_mask(0, 64'd1 << 3, 6'd0);
    chk_irq("R7 enable raises pending");
    rd_ok(4, 64'd1 << 3, "R7 active after enable write");
    wr_mask(0, 64'd1 << 4, 6'd0);
    chk_irq("R7 enable drop withdraws");
    chk("R7 irq0 low after drop", 64'(irq_o[0]), 64'd0);
    wr_mask(0, 64'd1 << 10, 6'd0);
    chk("R7 irq0 raised again", 64'(irq_o[0]), 64'd1);
    rd_ok(4, 64'd1 << 10, "R7 active new bit");

    // R9 size codes
    for (int s = 0; s < 3; s++) begin
      access(1'b1, 12'(64), 2'(s), 64'd0, d, e);
      chk("R9 narrow write error", {63'd0, e}, 64'd1);
      access(1'b0, 12'(64), 2'(s), 64'd0, d, e);
      chk("R9 narrow read error", {63'd0, e}, 64'd1);
      chk("R9 narrow read data zero", d, 64'd0);
    end
    rd_ok(1, mask_m[1], "R9 enable unchanged by narrow write");

    // R10 read-only and unmapped
    for (int i = 4; i < 9; i++) begin
      access(1'b1, 12'(i * 64), 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, d, e);
      chk("R10 write to read-only error", {63'd0, e}, 64'd1);
    end
    rd_ok(8, raw_m, "R10 pending unchanged by write");
    for (int c = 0; c < NCPU; c++) rd_ok(4 + c, mask_m[c] & raw_m, "R10 active unchanged by write");
    for (int i = 9; i < 64; i++) begin
      access(1'b0, 12'(i * 64), 2'd3, 64'd0, d, e);
      chk("R10 unmapped error", {63'd0, e}, 64'd1);
      chk("R10 unmapped data zero", d, 64'd0);
    end
    @(negedge clk);
    chk("R11 no response without request", {63'd0, csr_resp}, 64'd0);

    // R1 reset clears everything again
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    raw_m = '0;
    for (int c = 0; c < NCPU; c++) mask_m[c] = '0;
    chk("R1 irq after second reset", 64'(irq_o), 64'd0);
    for (int i = 0; i < 9; i++) rd_ok(i, 64'd0, "R1 register zero after second reset");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule